// File: doc/BRIEF.md
# Three-wire clock-chip serial target

This block is the target side of a three-wire synchronous serial link into a time and status register file. A host frames each transfer with an active-high select. It toggles a serial clock and moves data on one bidirectional line. The first byte of every transfer is a command. It names one of eight registers and a direction. The bytes that follow are either stored into that register, one byte lane at a time, or fetched from it and shifted back to the host. Time fields carried this way are BCD; the target passes them through unchanged.

All three link inputs are resynchronised to the block's system clock. Only rising edges of the serial clock are acted on. The host must keep each serial clock phase longer than about five system clock cycles. It must also hold the serial clock low whenever it changes select. Towards the register file the block offers a simple port: a one-cycle write strobe, a one-cycle read strobe, a register index and a byte lane. Read data is expected combinationally in the cycle of the read strobe. The data line is driven through a separate output-enable signal for an external pad buffer.

Top module: `rtc_serial_target`

## Requirements
- R1: The command byte is decoded with bit 0 as direction (1 = read, 0 = write) and bits 3:1 as register index (0 = status1 ... 7 = free register). It is accepted only when bits 7:4 equal 4'h6. The write codes are therefore 0x60, 0x62, 0x64, 0x66, 0x68, 0x6A, 0x6C and 0x6E, and each read code is the write code plus one.
- R2: Every byte on the link is least significant bit first and is captured on a serial clock rising edge. After a write command, each complete group of 8 data bits gives exactly one `reg_wr_o` pulse, carrying the decoded index, the current byte lane and the assembled byte.
- R3: The byte lane starts at 0 after the command byte and advances by one after every 8 data clocks. It saturates at MAX_BYTES-1 (6 by default), so extra bytes overwrite the last lane.
- R4: During a read, `sio_oe_o` stays low while the command byte is shifted in and goes high once it is complete. On the k-th following rising edge of a byte, bit k of that byte is placed on `sio_o` and held through the next falling edge.
- R5: A read issues one `reg_rd_o` pulse when the command completes and one more after each completed byte, each at the current index and lane.
- R6: Select going low at any point releases `sio_oe_o` and clears the bit counter, byte lane and command state. A partly shifted write byte is discarded and produces no write.
- R7: A command whose bits 7:4 differ from 4'h6 is ignored for the rest of that select window: no write strobe, no read strobe and no drive of the data line.
- R8: While `rst_ni` is low, `sio_oe_o`, `sio_o`, `reg_wr_o` and `reg_rd_o` are all 0.
- R9: Serial clock edges while select is low have no effect on the next transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Link select, active high |
| sck_i | input | 1 | Serial clock from host |
| sio_i | input | 1 | Data line as seen from the pad |
| sio_o | output | 1 | Data line value to drive |
| sio_oe_o | output | 1 | Data line output enable |
| reg_idx_o | output | 3 | Register index |
| reg_byte_o | output | $clog2(MAX_BYTES) | Byte lane within the register |
| reg_wr_o | output | 1 | Write strobe, one cycle |
| reg_wdata_o | output | 8 | Write byte |
| reg_rd_o | output | 1 | Read strobe, one cycle |
| reg_rdata_i | input | 8 | Read byte, valid with `reg_rd_o` |

## Verification
The bench goes after bit order and lane stepping, because a design that shifted MSB first or stepped the lane late would store bytes bit-reversed or in the wrong lane, and reading them back would not match. A select drop in mid-byte is tested, since a design that kept its counters across windows would misdecode the next command or commit a half-shifted byte. Commands with a wrong upper nibble are checked for silence on the data line and the write port. A run of nine bytes checks that the lane saturates and does not wrap onto lane 0. The read path is sampled just before each falling edge and the output enable is watched during the command byte, so a target that updated its bit on the wrong edge, or drove the line too early, shows as a bit shift or a bus fight.

// File: rtl/rtc_ser_pkg.sv
`timescale 1ns/1ps
package rtc_ser_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CMD,
    PH_WRITE,
    PH_READ,
    PH_IGNORE
  } phase_e;

  typedef struct packed {
    logic       valid;
    logic       rd;
    logic [2:0] idx;
  } cmd_t;
endpackage

// File: rtl/rtc_ser_sync.sv
`timescale 1ns/1ps
module rtc_ser_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] ff_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q <= '0;
      else         ff_q <= {ff_q[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = ff_q[STAGES-1];
  end
endmodule

// File: rtl/rtc_ser_edge.sv
`timescale 1ns/1ps
module rtc_ser_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end
  assign rise_o = lvl_i & ~lvl_q;

  // a rising edge is one cycle wide
  p_rise_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/rtc_ser_shift.sv
`timescale 1ns/1ps
module rtc_ser_shift #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] next_o
);
  logic [W-1:0] sh_q;
  // LSB first: newest bit enters at the top
  assign next_o = {bit_i, sh_q[W-1:1]};
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sh_q <= '0;
    else if (clr_i) sh_q <= '0;
    else if (en_i)  sh_q <= next_o;
  end
endmodule

// File: rtl/rtc_ser_cmd_dec.sv
`timescale 1ns/1ps
module rtc_ser_cmd_dec
  import rtc_ser_pkg::*;
#(
  parameter logic [3:0] CMD_TAG = 4'h6
) (
  input  logic [7:0] cmd_i,
  output cmd_t       dec_o
);
  always_comb begin
    dec_o.valid = (cmd_i[7:4] == CMD_TAG);
    dec_o.rd    = cmd_i[0];
    dec_o.idx   = cmd_i[3:1];
  end
endmodule

// File: rtl/rtc_serial_target.sv
`timescale 1ns/1ps
module rtc_serial_target
  import rtc_ser_pkg::*;
#(
  parameter int         MAX_BYTES   = 7,
  parameter int         DATA_W      = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] CMD_TAG     = 4'h6,
  localparam int        BYTE_W      = $clog2(MAX_BYTES),
  localparam int        BIT_W       = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              sck_i,
  input  logic              sio_i,
  output logic              sio_o,
  output logic              sio_oe_o,
  output logic [2:0]        reg_idx_o,
  output logic [BYTE_W-1:0] reg_byte_o,
  output logic              reg_wr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_rd_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  localparam logic [BYTE_W-1:0] LAST_LANE = BYTE_W'(MAX_BYTES - 1);
  localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(DATA_W - 1);

  logic sel_s, sck_s, sio_s, sck_rise;

  rtc_ser_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sel_i, sck_i, sio_i}),
    .q_o    ({sel_s, sck_s, sio_s})
  );

  rtc_ser_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (sck_s & sel_s),
    .rise_o (sck_rise)
  );

  phase_e            phase_q;
  logic [BIT_W-1:0]  bit_q;
  logic [BYTE_W-1:0] lane_q, wlane_q;
  logic [2:0]        idx_q;
  logic [DATA_W-1:0] rd_sh_q, wdata_q;
  logic              oe_q, out_q, fetch_q, wr_q;
  logic [7:0]        cmd_next;
  logic [DATA_W-1:0] wr_next;
  cmd_t              dec;
  logic              last_bit;
  logic [BYTE_W-1:0] lane_inc;

  rtc_ser_shift #(.W(8)) u_cmd_sh (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!sel_s),
    .en_i   (sck_rise && phase_q == PH_CMD),
    .bit_i  (sio_s),
    .next_o (cmd_next)
  );

  rtc_ser_shift #(.W(DATA_W)) u_wr_sh (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!sel_s || phase_q != PH_WRITE),
    .en_i   (sck_rise && phase_q == PH_WRITE),
    .bit_i  (sio_s),
    .next_o (wr_next)
  );

  rtc_ser_cmd_dec #(.CMD_TAG(CMD_TAG)) u_dec (
    .cmd_i (cmd_next),
    .dec_o (dec)
  );

  assign last_bit = (bit_q == LAST_BIT);
  assign lane_inc = (lane_q == LAST_LANE) ? lane_q : lane_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      bit_q   <= '0;
      lane_q  <= '0;
      wlane_q <= '0;
      idx_q   <= '0;
      rd_sh_q <= '0;
      wdata_q <= '0;
      oe_q    <= 1'b0;
      out_q   <= 1'b0;
      fetch_q <= 1'b0;
      wr_q    <= 1'b0;
    end else if (!sel_s) begin
      phase_q <= PH_IDLE;
      bit_q   <= '0;
      lane_q  <= '0;
      oe_q    <= 1'b0;
      out_q   <= 1'b0;
      fetch_q <= 1'b0;
      wr_q    <= 1'b0;
    end else begin
      wr_q    <= 1'b0;
      fetch_q <= 1'b0;
      if (phase_q == PH_IDLE) begin
        phase_q <= PH_CMD;
        bit_q   <= '0;
      end
      if (fetch_q) rd_sh_q <= reg_rdata_i;
      if (sck_rise) begin
        unique case (phase_q)
          PH_CMD: begin
            bit_q <= bit_q + 1'b1;
            if (last_bit) begin
              lane_q <= '0;
              idx_q  <= dec.idx;
              if (!dec.valid) begin
                phase_q <= PH_IGNORE;
              end else if (dec.rd) begin
                phase_q <= PH_READ;
                oe_q    <= 1'b1;
                fetch_q <= 1'b1;
              end else begin
                phase_q <= PH_WRITE;
              end
            end
          end
          PH_WRITE: begin
            bit_q <= bit_q + 1'b1;
            if (last_bit) begin
              wr_q    <= 1'b1;
              wdata_q <= wr_next;
              wlane_q <= lane_q;
              lane_q  <= lane_inc;
            end
          end
          PH_READ: begin
            out_q <= rd_sh_q[bit_q];
            bit_q <= bit_q + 1'b1;
            if (last_bit) begin
              lane_q  <= lane_inc;
              fetch_q <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sio_o       = out_q;
  assign sio_oe_o    = oe_q;
  assign reg_idx_o   = idx_q;
  assign reg_wr_o    = wr_q;
  assign reg_wdata_o = wdata_q;
  assign reg_rd_o    = fetch_q;
  assign reg_byte_o  = wr_q ? wlane_q : lane_q;

  p_lane_sat_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lane_q <= LAST_LANE);
  p_oe_read_only_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sio_oe_o |-> phase_q == PH_READ);
  p_oe_not_in_cmd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == PH_CMD |-> !sio_oe_o);
  p_wr_from_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |-> $past(phase_q) == PH_WRITE);
  p_rd_wr_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_wr_o && reg_rd_o));
  p_sel_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_s |=> !sio_oe_o && !reg_wr_o && !reg_rd_o);
  p_ignore_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == PH_IGNORE |-> !sio_oe_o && !reg_wr_o && !reg_rd_o);
endmodule

// File: tb/rtc_serial_target_bench.sv
`timescale 1ns/1ps
module rtc_serial_target_bench;
  logic clk = 1'b0, rst_n = 1'b0, sel = 1'b0, sck = 1'b0, sio = 1'b0;
  logic sio_o, oe, wr, rd;
  logic [2:0] idx, bidx;
  logic [7:0] wdata, rdata;
  logic [7:0] mem [8][8];
  int n_chk = 0, n_fail = 0, wr_cnt = 0, rd_cnt = 0, max_bidx = 0;
  logic oe_seen = 1'b0;
  logic [7:0] b;

  always #2.5 clk = ~clk;

  rtc_serial_target u_rtc_serial_target (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .sck_i(sck), .sio_i(sio),
    .sio_o(sio_o), .sio_oe_o(oe), .reg_idx_o(idx), .reg_byte_o(bidx),
    .reg_wr_o(wr), .reg_wdata_o(wdata), .reg_rd_o(rd), .reg_rdata_i(rdata)
  );

  // register file model
  always_comb rdata = mem[idx][bidx];
  always @(posedge clk) begin
    if (wr) begin
      mem[idx][bidx] <= wdata;
      wr_cnt = wr_cnt + 1;
      if (int'(bidx) > max_bidx) max_bidx = int'(bidx);
    end
    if (rd) rd_cnt = rd_cnt + 1;
    if (oe) oe_seen = 1'b1;
  end

  // {cmd, byte count, bytes with lane 0 in the low byte}
  localparam logic [39:0] VEC [8] = '{
    {8'h60, 8'd1, 24'h0000A5},
    {8'h62, 8'd1, 24'h00003C},
    {8'h64, 8'd3, 24'h241205},
    {8'h66, 8'd3, 24'h593012},
    {8'h68, 8'd1, 24'h000081},
    {8'h6A, 8'd2, 24'h007E01},
    {8'h6C, 8'd1, 24'h0000FF},
    {8'h6E, 8'd2, 24'h000055}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic start();
    sel = 1'b1; #40;
  endtask
  task automatic stop();
    #40 sel = 1'b0; #80;
  endtask
  task automatic send_bits(input logic [7:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      sio = v[i]; #40 sck = 1'b1; #40 sck = 1'b0;
    end
  endtask
  task automatic send(input logic [7:0] v);
    send_bits(v, 8);
  endtask
  task automatic recv(output logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      #40 sck = 1'b1; #38 v[i] = sio_o; #2 sck = 1'b0;
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(5 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    int w0, r0;
    for (int i = 0; i < 8; i++) for (int j = 0; j < 8; j++) mem[i][j] = 8'h00;
    #20;
    // R8 reset state
    chk("R8 oe", oe, 0);
    chk("R8 sio", sio_o, 0);
    chk("R8 wr", wr, 0);
    chk("R8 rd", rd, 0);
    rst_n = 1'b1; #40;

    // table walk: write each register, then read it back (R1 R2 R4 R5)
    for (int v = 0; v < 8; v++) begin
      logic [7:0] cmd;
      int n;
      cmd = VEC[v][39:32];
      n   = int'(VEC[v][31:24]);
      w0 = wr_cnt;
      start(); send(cmd);
      for (int k = 0; k < n; k++) send(VEC[v][8*k +: 8]);
      stop();
      chk("R2 write count", w0 + n, wr_cnt);
      for (int k = 0; k < n; k++)
        chk("R1 R2 stored byte", mem[cmd[3:1]][k], VEC[v][8*k +: 8]);
      r0 = rd_cnt;
      start(); send(cmd | 8'h01);
      chk("R4 oe after cmd", oe, 1);
      for (int k = 0; k < n; k++) begin
        recv(b);
        chk("R1 R4 read byte", b, VEC[v][8*k +: 8]);
      end
      stop();
      chk("R5 fetch count", rd_cnt - r0, n + 1);
      chk("R6 oe released", oe, 0);
    end

    // R4: no drive during the command byte
    oe_seen = 1'b0;
    start(); send_bits(8'h65, 7);
    chk("R4 oe during cmd", oe_seen, 0);
    send_bits(8'h00, 1);
    chk("R4 oe at cmd end", oe, 1);
    recv(b);
    chk("R4 read data1 lane0", b, 8'h05);
    stop();

    // R3: nine bytes into the free register, lane saturates at 6
    w0 = wr_cnt; max_bidx = 0;
    start(); send(8'h6E);
    for (int k = 0; k < 9; k++) send(8'h10 + 8'(k));
    stop();
    chk("R3 write count", wr_cnt - w0, 9);
    chk("R3 max lane", max_bidx, 6);
    chk("R3 lane5", mem[7][5], 8'h15);
    chk("R3 last lane", mem[7][6], 8'h18);
    chk("R3 lane0 kept", mem[7][0], 8'h10);

    // R6: select drop in mid-byte discards the partial byte
    w0 = wr_cnt;
    start(); send(8'h60); send_bits(8'hFF, 4);
    stop();
    chk("R6 no partial write", wr_cnt - w0, 0);
    start(); send(8'h61); recv(b); stop();
    chk("R6 fresh command", b, 8'hA5);

    // R7: bad upper nibble, read and write forms
    w0 = wr_cnt; r0 = rd_cnt; oe_seen = 1'b0;
    start(); send(8'h53); recv(b); stop();
    start(); send(8'h70); send(8'h99); stop();
    start(); send(8'hE2); send(8'h77); stop();
    chk("R7 no drive", oe_seen, 0);
    chk("R7 no write", wr_cnt - w0, 0);
    chk("R7 no fetch", rd_cnt - r0, 0);
    chk("R7 status2 intact", mem[1][0], 8'h3C);

    // R9: clocks with select low are ignored
    sio = 1'b1;
    for (int i = 0; i < 5; i++) begin #40 sck = 1'b1; #40 sck = 1'b0; end
    w0 = wr_cnt;
    start(); send(8'h62); send(8'h42); stop();
    chk("R9 one write", wr_cnt - w0, 1);
    chk("R9 status2 value", mem[1][0], 8'h42);
    chk("R9 status1 intact", mem[0][0], 8'hA5);

    finish_run();
  end
endmodule